// File: doc/BRIEF.md
# UART Register, Command and Interrupt Controller

This block is the software-facing side of a byte-oriented UART. A processor reaches it through a 64-byte window on a simple synchronous bus. Each access lasts one cycle. Read data is combinational from the current state, and any side effect of the access takes place at the closing clock edge. Behind the window sit two mode registers that share one access pointer, a status byte, a command register, a transmit holding byte, a four-entry receive FIFO, an interrupt status byte and an interrupt mask. A single interrupt line is driven from the status and mask bytes.

On the line side the block works on whole bytes. It gives a one-cycle transmit strobe with the data byte. It takes received bytes through a valid/ready pair, and it has a break-event input that places a zero byte in the FIFO. The serial shifter, baud timing and parity checking are outside this block. Writes to the clock-select offset (0x04) and the auxiliary-control offset (0x10) are accepted and have no effect.

Top module: `uart_ctrl`

## Requirements
- R1: Register map on addr_i. A write to 0x00 goes to the selected mode register. A read of 0x04 returns status. A write to 0x08 is a command. A write to 0x0C fills the transmit byte and a read of 0x0C pops the receive FIFO (0 when it is empty). A read of 0x14 returns interrupt status and a write of 0x14 sets the mask. Writes to 0x04 and 0x10 change nothing.
- R2: After reset, status reads 0x08, the interrupt status and mask are 0, irq_o is low, both directions are disabled and the FIFO is empty.
- R3: Status bits are: bit0 receive data ready (FIFO not empty), bit1 FIFO full, bit2 transmitter ready (transmitter enabled), bit3 transmit byte empty. Bits 7:4 read 0.
- R4: An access at 0x00 uses mode register 1 while the pointer is clear, and every such read or write then points it at mode register 2. The pointer stays there until a reset-pointer command or a block reset.
- R5: Command bits [6:4] select one action. 1 clears the mode pointer. 2 empties the FIFO. 3 sets transmit-empty and disables the transmitter, dropping any pending byte. 5 clears the break-change interrupt bit. 0, 4, 6 and 7 do nothing.
- R6: Command bits [3:2] control the transmitter and bits [1:0] control the receiver: 1 enables, 2 disables, 3 is ignored. These fields act after the bits [6:4] action in the same byte.
- R7: A write to 0x0C clears transmit-empty. In every cycle where the transmitter is enabled and the byte is pending, tx_valid_o is high with the byte. At the closing edge of that cycle transmit-empty is set, so each written byte is sent once.
- R8: The FIFO returns bytes oldest first. Status bit1 is set when it holds 4 entries. A read that takes an entry clears bit1, and bit0 clears when the last entry is read.
- R9: rx_ready_o is high exactly when the receiver is enabled and the FIFO is not full. A byte is stored only when rx_valid_i and rx_ready_o are both high.
- R10: A rx_break_i pulse sets interrupt status bit2 and stores a zero byte whether or not the receiver is enabled. If the FIFO is full, the zero byte overwrites the newest entry. In the same cycle the break takes priority over rx_valid_i.
- R11: Interrupt status bit0 equals transmitter ready. Bit1 equals FIFO-full when mode register 1 bit6 is set, and receive-ready otherwise. Bit7 reads 0. irq_o is high when any interrupt status bit is set whose mask bit is also set.
- R12: A FIFO read and a store in the same cycle pop the oldest byte and append the new one. A transmit write in a cycle where a byte is being sent emits the old byte and keeps the new one pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 6 | Byte offset inside the window |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the current access |
| irq_o | output | 1 | Interrupt request |
| tx_valid_o | output | 1 | Transmit byte strobe |
| tx_data_o | output | 8 | Transmit byte |
| rx_valid_i | input | 1 | Received byte offered |
| rx_data_i | input | 8 | Received byte |
| rx_ready_o | output | 1 | Receive byte can be accepted |
| rx_break_i | input | 1 | Break event, one cycle |

## Verification
Two pairs of functions can meet in one cycle. The first is a bus read that pops the FIFO while the line side stores a byte. The bench provokes it by raising rx_valid_i in the same cycle as a read of 0x0C. It then judges the result by reading the remaining bytes in order and checking that none was lost or duplicated. The second is a transmit write that lands in the cycle where the previous byte is on tx_valid_o. There the bench checks the old byte at the strobe before the edge and the new byte on the strobe in the following cycle, and it also covers a break arriving while the FIFO is full.

// File: rtl/uart_ctrl_pkg.sv
package uart_ctrl_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned OFS_W  = 6;

  localparam logic [OFS_W-1:0] OFS_MODE = 6'h00;
  localparam logic [OFS_W-1:0] OFS_STAT = 6'h04;
  localparam logic [OFS_W-1:0] OFS_CMD  = 6'h08;
  localparam logic [OFS_W-1:0] OFS_DATA = 6'h0C;
  localparam logic [OFS_W-1:0] OFS_AUX  = 6'h10;
  localparam logic [OFS_W-1:0] OFS_INT  = 6'h14;

  // bit used in mode register 1 to pick the receive interrupt source
  localparam int unsigned MODE_RXSRC_BIT = 6;

  typedef enum logic [2:0] {
    MISC_NOP     = 3'd0,
    MISC_PTR_RST = 3'd1,
    MISC_RX_RST  = 3'd2,
    MISC_TX_RST  = 3'd3,
    MISC_ERR_RST = 3'd4,
    MISC_BRK_ACK = 3'd5,
    MISC_BRK_ON  = 3'd6,
    MISC_BRK_OFF = 3'd7
  } misc_cmd_e;

  typedef enum logic [1:0] {
    DIR_KEEP = 2'd0,
    DIR_ON   = 2'd1,
    DIR_OFF  = 2'd2,
    DIR_RSVD = 2'd3
  } dir_cmd_e;

  typedef struct packed {
    logic ptr_rst;
    logic rx_rst;
    logic tx_rst;
    logic brk_ack;
    logic tx_on;
    logic tx_off;
    logic rx_on;
    logic rx_off;
  } cmd_strb_t;
endpackage

// File: rtl/uart_cmd_dec.sv
module uart_cmd_dec
  import uart_ctrl_pkg::*;
(
  input  logic      cmd_wr_i,
  input  logic [6:0] cmd_i,
  output cmd_strb_t strb_o
);
  misc_cmd_e misc;
  dir_cmd_e  tx_f, rx_f;

  always_comb begin
    misc = misc_cmd_e'(cmd_i[6:4]);
    tx_f = dir_cmd_e'(cmd_i[3:2]);
    rx_f = dir_cmd_e'(cmd_i[1:0]);
    strb_o = '0;
    if (cmd_wr_i) begin
      strb_o.ptr_rst = (misc == MISC_PTR_RST);
      strb_o.rx_rst  = (misc == MISC_RX_RST);
      strb_o.tx_rst  = (misc == MISC_TX_RST);
      strb_o.brk_ack = (misc == MISC_BRK_ACK);
      strb_o.tx_on   = (tx_f == DIR_ON);
      strb_o.tx_off  = (tx_f == DIR_OFF);
      strb_o.rx_on   = (rx_f == DIR_ON);
      strb_o.rx_off  = (rx_f == DIR_OFF);
    end
  end
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold
  import uart_ctrl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              en_i,
  input  logic              flush_i,
  output logic              empty_o,
  output logic              tx_valid_o,
  output logic [BYTE_W-1:0] tx_data_o
);
  logic              empty_q;
  logic [BYTE_W-1:0] data_q;

  assign tx_valid_o = en_i & ~empty_q;
  assign tx_data_o  = data_q;
  assign empty_o    = empty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      empty_q <= 1'b1;
      data_q  <= '0;
    end else begin
      if (wr_i) begin
        data_q  <= wdata_i;
        empty_q <= 1'b0;
      end else if (tx_valid_o || flush_i) begin
        empty_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_ctrl_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              push_i,
  input  logic [BYTE_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [BYTE_W-1:0] head_o,
  output logic              nonempty_o,
  output logic              full_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [BYTE_W-1:0] q [DEPTH];
  logic [BYTE_W-1:0] q_nxt [DEPTH];
  logic [CNT_W-1:0]  cnt_q, cnt_nxt;

  assign head_o     = q[0];
  assign nonempty_o = (cnt_q != '0);
  assign full_o     = (cnt_q == FULL_CNT);

  always_comb begin
    cnt_nxt = cnt_q;
    for (int i = 0; i < DEPTH; i++) q_nxt[i] = q[i];
    if (pop_i && nonempty_o) begin
      for (int i = 0; i < DEPTH - 1; i++) q_nxt[i] = q[i+1];
      cnt_nxt = cnt_q - 1'b1;
    end
    if (push_i) begin
      if (cnt_nxt == FULL_CNT) begin
        q_nxt[DEPTH-1] = push_data_i;  // overwrite newest
      end else begin
        for (int i = 0; i < DEPTH; i++)
          if (cnt_nxt == CNT_W'(i)) q_nxt[i] = push_data_i;
        cnt_nxt = cnt_nxt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) q[i] <= '0;
    end else if (flush_i) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_nxt;
      for (int i = 0; i < DEPTH; i++) q[i] <= q_nxt[i];
    end
  end
endmodule

// File: rtl/uart_ctrl.sv
module uart_ctrl
  import uart_ctrl_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [OFS_W-1:0]  addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              tx_valid_o,
  output logic [BYTE_W-1:0] tx_data_o,
  input  logic              rx_valid_i,
  input  logic [BYTE_W-1:0] rx_data_i,
  output logic              rx_ready_o,
  input  logic              rx_break_i
);
  logic              wr, rd, tb_wr, pop, push;
  logic [BYTE_W-1:0] push_data, rx_head, status, isr, imr_q;
  logic [BYTE_W-1:0] mode_q [2];
  logic              mode_ptr_q, tx_en_q, rx_en_q, brk_q;
  logic              tx_empty, rx_nonempty, rx_full, rx_int;
  cmd_strb_t         strb;

  assign wr    = req_i & we_i;
  assign rd    = req_i & ~we_i;
  assign tb_wr = wr & (addr_i == OFS_DATA);
  assign pop   = rd & (addr_i == OFS_DATA);

  uart_cmd_dec u_cmd (
    .cmd_wr_i (wr & (addr_i == OFS_CMD)),
    .cmd_i    (wdata_i[6:0]),
    .strb_o   (strb)
  );

  uart_tx_hold u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (tb_wr),
    .wdata_i    (wdata_i),
    .en_i       (tx_en_q),
    .flush_i    (strb.tx_rst),
    .empty_o    (tx_empty),
    .tx_valid_o (tx_valid_o),
    .tx_data_o  (tx_data_o)
  );

  assign rx_ready_o = rx_en_q & ~rx_full;
  assign push       = rx_break_i | (rx_valid_i & rx_ready_o);
  assign push_data  = rx_break_i ? '0 : rx_data_i;

  uart_rx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (strb.rx_rst),
    .push_i      (push),
    .push_data_i (push_data),
    .pop_i       (pop),
    .head_o      (rx_head),
    .nonempty_o  (rx_nonempty),
    .full_o      (rx_full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q[0]  <= '0;
      mode_q[1]  <= '0;
      mode_ptr_q <= 1'b0;
      imr_q      <= '0;
      tx_en_q    <= 1'b0;
      rx_en_q    <= 1'b0;
      brk_q      <= 1'b0;
    end else begin
      if (req_i && addr_i == OFS_MODE) begin
        if (we_i) mode_q[mode_ptr_q] <= wdata_i;
        mode_ptr_q <= 1'b1;
      end
      if (strb.ptr_rst) mode_ptr_q <= 1'b0;
      if (wr && addr_i == OFS_INT) imr_q <= wdata_i;
      // direction fields act after the misc action
      if (strb.tx_rst) tx_en_q <= 1'b0;
      if (strb.tx_on) tx_en_q <= 1'b1;
      else if (strb.tx_off) tx_en_q <= 1'b0;
      if (strb.rx_on) rx_en_q <= 1'b1;
      else if (strb.rx_off) rx_en_q <= 1'b0;
      if (rx_break_i) brk_q <= 1'b1;
      else if (strb.brk_ack) brk_q <= 1'b0;
    end
  end

  assign rx_int = mode_q[0][MODE_RXSRC_BIT] ? rx_full : rx_nonempty;
  assign status = {4'b0000, tx_empty, tx_en_q, rx_full, rx_nonempty};
  assign isr    = {1'b0, 4'b0000, brk_q, rx_int, tx_en_q};
  assign irq_o  = |(isr & imr_q);

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      unique case (addr_i)
        OFS_MODE: rdata_o = mode_q[mode_ptr_q];
        OFS_STAT: rdata_o = status;
        OFS_DATA: rdata_o = rx_nonempty ? rx_head : '0;
        OFS_INT:  rdata_o = isr;
        default:  rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/uart_ctrl_chk.sv
module uart_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tx_valid_o,
  input logic       tb_wr,
  input logic       rx_ready_o,
  input logic       rx_break_i,
  input logic       pop,
  input logic       push,
  input logic [7:0] status,
  input logic [7:0] isr
);
  // R7
  tx_single_emit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tb_wr |=> !tx_valid_o);

  // R7
  tx_empty_after_emit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tb_wr |=> status[3]);

  // R9
  rx_ready_not_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ready_o |-> !status[1]);

  // R10
  brk_flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_break_i |=> isr[2]);

  // R8
  pop_clears_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop && status[1] && !push |=> !status[1]);

  // R10
  brk_stores_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_break_i && !pop |=> status[0]);
endmodule

bind uart_ctrl uart_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tx_valid_o (tx_valid_o),
  .tb_wr      (tb_wr),
  .rx_ready_o (rx_ready_o),
  .rx_break_i (rx_break_i),
  .pop        (pop),
  .push       (push),
  .status     (status),
  .isr        (isr)
);

// File: tb/uart_ctrl_tb_top.sv
`timescale 1ns/1ps
module uart_ctrl_tb_top;
  localparam real CLK_P = 5.0;

  typedef struct packed {
    logic       we;
    logic [5:0] addr;
    logic [7:0] wd;
    logic       chk_rd;
    logic [7:0] exp_rd;
    logic       exp_irq;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 6'h04, 8'h00, 1'b1, 8'h08, 1'b0},  // R3 idle status
    '{1'b1, 6'h00, 8'h40, 1'b0, 8'h00, 1'b0},  // R4 MR1
    '{1'b1, 6'h00, 8'h13, 1'b0, 8'h00, 1'b0},  // R4 MR2
    '{1'b0, 6'h00, 8'h00, 1'b1, 8'h13, 1'b0},  // R4 stays MR2
    '{1'b1, 6'h08, 8'h10, 1'b0, 8'h00, 1'b0},  // R5 ptr reset
    '{1'b0, 6'h00, 8'h00, 1'b1, 8'h40, 1'b0},
    '{1'b0, 6'h00, 8'h00, 1'b1, 8'h13, 1'b0},
    '{1'b1, 6'h14, 8'h03, 1'b0, 8'h00, 1'b0},  // R1 mask
    '{1'b1, 6'h08, 8'h05, 1'b0, 8'h00, 1'b0},  // R6 both on
    '{1'b0, 6'h04, 8'h00, 1'b1, 8'h0C, 1'b1},  // R11 txint
    '{1'b0, 6'h14, 8'h00, 1'b1, 8'h01, 1'b1},
    '{1'b1, 6'h08, 8'h08, 1'b0, 8'h00, 1'b1},  // R6 tx off
    '{1'b0, 6'h04, 8'h00, 1'b1, 8'h08, 1'b0},
    '{1'b1, 6'h08, 8'h0F, 1'b0, 8'h00, 1'b0},  // R6 reserved
    '{1'b1, 6'h04, 8'hFF, 1'b0, 8'h00, 1'b0},  // R1 ignored
    '{1'b1, 6'h10, 8'hFF, 1'b0, 8'h00, 1'b0},  // R1 ignored
    '{1'b0, 6'h04, 8'h00, 1'b1, 8'h08, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0, rxv = 1'b0, brk = 1'b0;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0, rxd = '0;
  logic [7:0] rdata, txd;
  logic irq, txv, rxr;
  int n_run = 0, n_fail = 0;
  logic [7:0] r;
  logic ir;

  always #(CLK_P/2) clk = ~clk;

  uart_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .tx_valid_o(txv),
    .tx_data_o(txd), .rx_valid_i(rxv), .rx_data_i(rxd), .rx_ready_o(rxr),
    .rx_break_i(brk)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic [5:0] a, input logic [7:0] d,
                     output logic [7:0] rd_v, output logic irq_v);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    #1 rd_v = rdata; irq_v = irq;
    @(posedge clk); #1 req = 1'b0; we = 1'b0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    logic [7:0] x; logic y;
    bus(1'b1, a, d, x, y);
  endtask

  task automatic rd_chk(input string tag, input logic [5:0] a, input logic [7:0] exp);
    logic [7:0] x; logic y;
    bus(1'b0, a, 8'h00, x, y);
    check(tag, x, exp);
  endtask

  task automatic rx_byte(input logic [7:0] d);
    @(negedge clk); rxv = 1'b1; rxd = d;
    @(posedge clk); #1 rxv = 1'b0;
  endtask

  task automatic brk_pulse();
    @(negedge clk); brk = 1'b1;
    @(posedge clk); #1 brk = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle(2); rst_n = 1'b1; idle(1);
    @(negedge clk);
    check("R2 irq", {7'b0, irq}, 8'h00);
    check("R2 rx_ready", {7'b0, rxr}, 8'h00);
    check("R2 tx_valid", {7'b0, txv}, 8'h00);
    rd_chk("R2 status", 6'h04, 8'h08);
    rd_chk("R2 isr", 6'h14, 8'h00);

    for (int i = 0; i < NV; i++) begin
      bus(VECS[i].we, VECS[i].addr, VECS[i].wd, r, ir);
      if (VECS[i].chk_rd) check($sformatf("R1 vec%0d rdata", i), r, VECS[i].exp_rd);
      check($sformatf("R11 vec%0d irq", i), {7'b0, ir}, {7'b0, VECS[i].exp_irq});
    end
    rd_chk("R4 MR after aux write", 6'h00, 8'h13);
    check("R6 rx still on", {7'b0, rxr}, 8'h01);

    // FIFO order and full flag, RxINT on full (MR1 bit6 set)
    rx_byte(8'hA1); rx_byte(8'hA2); rx_byte(8'hA3);
    bus(1'b0, 6'h04, 8'h00, r, ir);
    check("R8 status 3 entries", r, 8'h09);
    check("R11 no rxint below full", {7'b0, ir}, 8'h00);
    rx_byte(8'hA4);
    bus(1'b0, 6'h04, 8'h00, r, ir);
    check("R8 status full", r, 8'h0B);
    check("R11 rxint on full", {7'b0, ir}, 8'h01);
    check("R9 ready low when full", {7'b0, rxr}, 8'h00);
    rx_byte(8'hEE);  // dropped
    rd_chk("R8 pop 1", 6'h0C, 8'hA1);
    rd_chk("R8 full cleared", 6'h04, 8'h09);
    rd_chk("R8 pop 2", 6'h0C, 8'hA2);
    rd_chk("R8 pop 3", 6'h0C, 8'hA3);
    rd_chk("R9 pop 4 no overrun byte", 6'h0C, 8'hA4);
    rd_chk("R8 empty", 6'h04, 8'h08);
    rd_chk("R1 empty read", 6'h0C, 8'h00);

    // simultaneous pop and store
    rx_byte(8'hB1); rx_byte(8'hB2);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = 6'h0C; rxv = 1'b1; rxd = 8'hB3;
    #1 r = rdata;
    @(posedge clk); #1 req = 1'b0; rxv = 1'b0;
    check("R12 pop with push", r, 8'hB1);
    rd_chk("R12 next", 6'h0C, 8'hB2);
    rd_chk("R12 appended", 6'h0C, 8'hB3);
    rd_chk("R12 drained", 6'h04, 8'h08);

    // break on full FIFO
    rx_byte(8'hC1); rx_byte(8'hC2); rx_byte(8'hC3); rx_byte(8'hC4);
    brk_pulse();
    rd_chk("R10 isr break", 6'h14, 8'h06);
    rd_chk("R10 c1", 6'h0C, 8'hC1);
    rd_chk("R10 c2", 6'h0C, 8'hC2);
    rd_chk("R10 c3", 6'h0C, 8'hC3);
    rd_chk("R10 zero overwrote newest", 6'h0C, 8'h00);
    wr(6'h08, 8'h50);
    rd_chk("R5 break ack", 6'h14, 8'h00);

    // transmit
    wr(6'h08, 8'h04);
    wr(6'h0C, 8'h5A);
    check("R7 strobe", {7'b0, txv}, 8'h01);
    check("R7 data", txd, 8'h5A);
    rd_chk("R7 pending status", 6'h04, 8'h04);
    check("R7 single strobe", {7'b0, txv}, 8'h00);
    rd_chk("R7 empty again", 6'h04, 8'h0C);

    wr(6'h0C, 8'h11);
    check("R12 first strobe data", txd, 8'h11);
    wr(6'h0C, 8'h22);
    check("R12 second strobe", {7'b0, txv}, 8'h01);
    check("R12 second data", txd, 8'h22);
    idle(1);
    check("R12 strobe ends", {7'b0, txv}, 8'h00);

    // disabled transmitter holds
    wr(6'h08, 8'h08);
    wr(6'h0C, 8'h66);
    idle(3);
    check("R7 held while off", {7'b0, txv}, 8'h00);
    rd_chk("R7 status held", 6'h04, 8'h00);
    wr(6'h08, 8'h04);
    check("R7 sent on enable", {7'b0, txv}, 8'h01);
    check("R7 sent data", txd, 8'h66);
    idle(1);

    // transmitter reset drops pending byte
    wr(6'h08, 8'h08);
    wr(6'h0C, 8'h77);
    wr(6'h08, 8'h30);
    rd_chk("R5 tx reset status", 6'h04, 8'h08);
    wr(6'h08, 8'h04);
    check("R5 nothing sent", {7'b0, txv}, 8'h00);
    rd_chk("R5 tx ready", 6'h04, 8'h0C);
    wr(6'h08, 8'h08);

    // receiver reset
    rx_byte(8'hD1); rx_byte(8'hD2);
    wr(6'h08, 8'h20);
    rd_chk("R5 rx reset", 6'h04, 8'h08);
    check("R5 rx still enabled", {7'b0, rxr}, 8'h01);

    // RxINT on RxRDY when MR1 bit6 clear
    wr(6'h08, 8'h10);
    wr(6'h00, 8'h00);
    rx_byte(8'h33);
    @(negedge clk);
    check("R11 rxint on ready", {7'b0, irq}, 8'h01);
    rd_chk("R11 isr", 6'h14, 8'h02);
    rd_chk("R8 data", 6'h0C, 8'h33);
    @(negedge clk);
    check("R11 irq cleared", {7'b0, irq}, 8'h00);

    // receiver disabled
    wr(6'h08, 8'h02);
    check("R9 ready low when off", {7'b0, rxr}, 8'h00);
    rx_byte(8'h44);
    rd_chk("R9 not stored", 6'h04, 8'h08);

    // reset again
    @(negedge clk); rst_n = 1'b0; idle(1); rst_n = 1'b1;
    rd_chk("R2 status after reset", 6'h04, 8'h08);
    rd_chk("R2 MR1 after reset", 6'h00, 8'h00);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule